// File: doc/BRIEF.md
# Divider-Fed Two-Phase Buck Gate Sequencer

This block produces the nine gate drives for a two-phase interleaved buck stage whose input bulk capacitor is replaced by a two-capacitor switched divider. Each switching period is a fixed number of clocks. Within it, a free-running period count sets the on-time of each phase from one duty command, and the two phases run half a period apart. A complementary pair with a dead-time gap drives each phase. While the upper phase's low-side rectifier conducts, a charge window recharges the series capacitor stack. For the rest of the period, a split configuration ties the upper capacitor to the upper phase and the lower capacitor to the lower phase.

A transient-detect input forces a bypass configuration at once. In bypass, a single link switch applies the full input to both phases, and the divider is no longer cycled. The PWM keeps running while the block is in bypass. The block returns to split operation only at a period boundary, and only after the transient input has been low for a whole period. The duty command and the dead-time setting are also taken only at the period boundary.

The controller has four states. ST_IDLE holds all gates off for the first clock after reset. ST_SPLIT is the normal state. ST_CHARGE holds the charge window. ST_BYPASS is the transient configuration. ST_IDLE always moves to ST_SPLIT. ST_SPLIT moves to ST_CHARGE on the clock before the upper rectifier turns on. ST_CHARGE returns to ST_SPLIT when its count runs out or the period ends. ST_BYPASS returns to ST_SPLIT at a boundary after a quiet period. A raised transient input moves any state to ST_BYPASS.

Top module: `dsb_gate_seq`

## Requirements
- R1: While reset is low, and for the first clock after it rises, all nine gate outputs are low.
- R2: The period count runs 0..PERIOD-1 (0..99 by default). The upper phase requests its high side while count < duty and its low side otherwise. The gates follow the request one clock later, and each turn-on is delayed by the dead time.
- R3: The lower phase behaves as in R2, but it compares (count + PERIOD/2) mod PERIOD against the duty.
- R4: A change of request turns both gates of that phase off for exactly dt clocks before the new side turns on. The high and low gates of a phase are never on together.
- R5: The duty and dead-time inputs are captured only on the last count of a period and apply from count 0. A duty above PERIOD is clamped to PERIOD, and a dead time of 0 is treated as 1. After reset the duty is 0 and the dead time is 1.
- R6: In split state both tap gates are high, and the charge and link gates are low.
- R7: The charge window begins on the first clock of upper low-side conduction, at count duty+dt+1. During the window both charge gates are high, both tap gates are low, the upper high side is off and the upper low side is on.
- R8: The charge window lasts chg_len clocks. It is cut off after count PERIOD-1, and no window opens when chg_len is 0 or when duty+dt >= PERIOD-1.
- R9: A high transient input drives the link gate high on the next clock. It also removes the tap and charge gates, while both phases keep switching.
- R10: Bypass ends only at a period boundary, when the transient input has been low for the last PERIOD clocks. Split state then begins at count 0.
- R11: The link gate is never high together with any tap or charge gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_cmd | input | 7 | High-side on-time in counts (0..PERIOD) |
| dt_cfg | input | 2 | Dead time in clocks (1..3, 0 means 1) |
| chg_len | input | 6 | Charge window length in clocks |
| surge_in | input | 1 | Transient-detect flag |
| g_chg_hi | output | 1 | Divider charge path, upper switch |
| g_chg_lo | output | 1 | Divider charge path, lower switch |
| g_tap_up | output | 1 | Upper capacitor to upper phase |
| g_tap_lo | output | 1 | Lower capacitor to lower phase |
| g_link | output | 1 | Divider bypass link |
| g_up_hs | output | 1 | Upper phase high side |
| g_up_ls | output | 1 | Upper phase low side (rectifier) |
| g_lo_hs | output | 1 | Lower phase high side |
| g_lo_ls | output | 1 | Lower phase low side |

## Verification
The tap, charge and link gates decode directly from the state register. A wrong state therefore appears on those ports in the same clock as the fault: a tap dropping outside a window, a charge pulse of the wrong length, or a link that releases off a boundary. A wrong period count or a mis-latched duty shows up within one period as phase edges at the wrong count. A dead-time fault shows up within dt clocks of the next request change. Because the bench compares every gate on every clock, each of these faults is reported on the clock where it first appears.

// File: rtl/dsb_pkg.sv
`timescale 1ns/1ps
package dsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPLIT  = 2'd1,
        ST_CHARGE = 2'd2,
        ST_BYPASS = 2'd3
    } seq_state_e;

    localparam int NUM_LEGS = 2;
endpackage

// File: rtl/dsb_period_ctr.sv
`timescale 1ns/1ps
module dsb_period_ctr #(
    parameter int PERIOD = 100,
    parameter int DT_W   = 2,
    parameter int CNT_W  = $clog2(PERIOD),
    parameter int DUTY_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic [DT_W-1:0]   dt_cfg,
    output logic [CNT_W-1:0]  cnt,
    output logic [DUTY_W-1:0] duty_q,
    output logic [DT_W-1:0]   dt_q,
    output logic              wrap
);
    localparam logic [CNT_W-1:0]  LAST = CNT_W'(PERIOD - 1);
    localparam logic [DUTY_W-1:0] DMAX = DUTY_W'(PERIOD);

    assign wrap = (cnt == LAST);

    // Period counter; settings are captured on the last count only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            duty_q <= '0;
            dt_q   <= DT_W'(1);
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap) begin
                duty_q <= (duty_cmd > DMAX) ? DMAX : duty_cmd;
                dt_q   <= (dt_cfg == '0) ? DT_W'(1) : dt_cfg;
            end
        end
    end
endmodule

// File: rtl/dsb_leg.sv
`timescale 1ns/1ps
module dsb_leg #(
    parameter int DT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [DT_W-1:0] dt_q,
    output logic            hs,
    output logic            ls
);
    logic            last_q;
    logic [DT_W-1:0] hold_q;

    // A request change reloads the gap timer; both sides stay off until it empties
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            hold_q <= '0;
        end else if (req != last_q) begin
            last_q <= req;
            hold_q <= dt_q;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign hs = (hold_q == '0) &&  last_q;
    assign ls = (hold_q == '0) && !last_q;
endmodule

// File: rtl/dsb_gate_seq.sv
`timescale 1ns/1ps
module dsb_gate_seq
    import dsb_pkg::*;
#(
    parameter  int PERIOD = 100,
    parameter  int CHG_W  = 6,
    parameter  int DT_W   = 2,
    localparam int CNT_W  = $clog2(PERIOD),
    localparam int DUTY_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic [DT_W-1:0]   dt_cfg,
    input  logic [CHG_W-1:0]  chg_len,
    input  logic              surge_in,
    output logic              g_chg_hi,
    output logic              g_chg_lo,
    output logic              g_tap_up,
    output logic              g_tap_lo,
    output logic              g_link,
    output logic              g_up_hs,
    output logic              g_up_ls,
    output logic              g_lo_hs,
    output logic              g_lo_ls
);
    localparam int PW    = CNT_W + 1;
    localparam int CMP_W = CNT_W + 2;
    localparam int QW    = $clog2(PERIOD + 1);

    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_q;
    logic [DT_W-1:0]   dt_q;
    logic              wrap;
    logic [NUM_LEGS-1:0] leg_hs, leg_ls;

    seq_state_e       state_q, state_d;
    logic [CHG_W-1:0] left_q, left_d;
    logic [QW-1:0]    quiet_q;
    logic             quiet_full, chg_start, run;

    dsb_period_ctr #(.PERIOD(PERIOD), .DT_W(DT_W), .CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .dt_cfg(dt_cfg),
        .cnt(cnt), .duty_q(duty_q), .dt_q(dt_q), .wrap(wrap)
    );

    // One dead-time leg per phase, each offset by an equal share of the period
    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        localparam int OFS = i * (PERIOD / NUM_LEGS);
        logic [PW-1:0] raw, pos;
        logic          req;
        assign raw = {1'b0, cnt} + PW'(OFS);
        assign pos = (raw >= PW'(PERIOD)) ? raw - PW'(PERIOD) : raw;
        assign req = CMP_W'(pos) < CMP_W'(duty_q);
        dsb_leg #(.DT_W(DT_W)) u_leg (
            .clk(clk), .rst_n(rst_n), .req(req), .dt_q(dt_q),
            .hs(leg_hs[i]), .ls(leg_ls[i])
        );
    end

    // Rectifier turns on the clock after count duty+dt
    assign chg_start  = (CMP_W'(cnt) == CMP_W'(duty_q) + CMP_W'(dt_q)) && !wrap && (chg_len != '0);
    assign quiet_full = (quiet_q == QW'(PERIOD - 1));

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (surge_in) begin
            state_d = ST_BYPASS;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_SPLIT;
                ST_SPLIT:  if (chg_start) begin
                               state_d = ST_CHARGE;
                               left_d  = chg_len;
                           end
                ST_CHARGE: if (left_q == CHG_W'(1) || wrap) state_d = ST_SPLIT;
                           else left_d = left_q - 1'b1;
                ST_BYPASS: if (wrap && quiet_full) state_d = ST_SPLIT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register with quiet-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            quiet_q <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            quiet_q <= surge_in ? '0 : (quiet_full ? quiet_q : quiet_q + 1'b1);
        end
    end

    // Output decode
    always_comb begin
        g_chg_hi = 1'b0;
        g_chg_lo = 1'b0;
        g_tap_up = 1'b0;
        g_tap_lo = 1'b0;
        g_link   = 1'b0;
        run      = 1'b1;
        unique case (state_q)
            ST_IDLE:   run = 1'b0;
            ST_SPLIT:  begin
                           g_tap_up = 1'b1;
                           g_tap_lo = 1'b1;
                       end
            ST_CHARGE: begin
                           g_chg_hi = leg_ls[0];
                           g_chg_lo = leg_ls[0];
                       end
            ST_BYPASS: g_link = 1'b1;
            default:   run = 1'b0;
        endcase
        g_up_hs = run && leg_hs[0];
        g_up_ls = run && leg_ls[0];
        g_lo_hs = run && leg_hs[1];
        g_lo_ls = run && leg_ls[1];
    end
endmodule

// File: rtl/dsb_gate_seq_chk.sv
`timescale 1ns/1ps
module dsb_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic surge_in,
    input logic g_chg_hi,
    input logic g_chg_lo,
    input logic g_tap_up,
    input logic g_tap_lo,
    input logic g_link,
    input logic g_up_hs,
    input logic g_up_ls,
    input logic g_lo_hs,
    input logic g_lo_ls
);
    // R4
    up_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(g_up_hs && g_up_ls));
    // R4
    lo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(g_lo_hs && g_lo_ls));
    // R4
    up_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(g_up_hs) |-> !$past(g_up_ls));
    // R4
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(g_lo_ls) |-> !$past(g_lo_hs));
    // R7
    chg_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_chg_hi |-> (g_up_ls && !g_up_hs && !g_tap_up && !g_tap_lo));
    // R8
    chg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) g_chg_hi == g_chg_lo);
    // R6
    tap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) g_tap_up == g_tap_lo);
    // R11
    link_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_link |-> !(g_tap_up || g_tap_lo || g_chg_hi || g_chg_lo));
    // R9
    bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) surge_in |=> g_link);
    // R10
    bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(g_link) |-> !$past(surge_in));
endmodule

bind dsb_gate_seq dsb_gate_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .surge_in(surge_in),
    .g_chg_hi(g_chg_hi), .g_chg_lo(g_chg_lo), .g_tap_up(g_tap_up), .g_tap_lo(g_tap_lo),
    .g_link(g_link), .g_up_hs(g_up_hs), .g_up_ls(g_up_ls), .g_lo_hs(g_lo_hs), .g_lo_ls(g_lo_ls)
);

// File: tb/sim_dsb_gate_seq.sv
`timescale 1ns/1ps
module sim_dsb_gate_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] duty_cmd = '0;
    logic [1:0] dt_cfg = 2'd1;
    logic [5:0] chg_len = '0;
    logic       surge_in = 1'b0;
    logic g_chg_hi, g_chg_lo, g_tap_up, g_tap_lo, g_link, g_up_hs, g_up_ls, g_lo_hs, g_lo_ls;

    int    checks = 0;
    int    errors = 0;
    string scen = "R1 reset";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    dsb_gate_seq u0 (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .dt_cfg(dt_cfg), .chg_len(chg_len),
        .surge_in(surge_in), .g_chg_hi(g_chg_hi), .g_chg_lo(g_chg_lo), .g_tap_up(g_tap_up),
        .g_tap_lo(g_tap_lo), .g_link(g_link), .g_up_hs(g_up_hs), .g_up_ls(g_up_ls),
        .g_lo_hs(g_lo_hs), .g_lo_ls(g_lo_ls)
    );

    // Behavioural reference: 0 idle, 1 split, 2 charge, 3 bypass
    int m_cnt, m_duty, m_dt, m_mode, m_left, m_quiet;
    int m_prev[2], m_age[2], m_gap[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_duty = 0; m_dt = 1; m_mode = 0; m_left = 0; m_quiet = 0;
            for (int i = 0; i < 2; i++) begin
                m_prev[i] = 0; m_age[i] = 1000; m_gap[i] = 1;
            end
        end else begin
            int nm, nl;
            for (int i = 0; i < 2; i++) begin
                int pos, rq;
                pos = (m_cnt + i * 50) % 100;
                rq  = (pos < m_duty) ? 1 : 0;
                if (rq != m_prev[i]) begin
                    m_prev[i] = rq; m_age[i] = 0; m_gap[i] = m_dt;
                end else if (m_age[i] < 1000) begin
                    m_age[i]++;
                end
            end
            nm = m_mode; nl = m_left;
            if (surge_in) nm = 3;
            else if (m_mode == 0) nm = 1;
            else if (m_mode == 1) begin
                if (m_cnt == m_duty + m_dt && m_cnt != 99 && chg_len != 0) begin
                    nm = 2; nl = int'(chg_len);
                end
            end else if (m_mode == 2) begin
                if (m_left == 1 || m_cnt == 99) nm = 1;
                else nl = m_left - 1;
            end else begin
                if (m_cnt == 99 && m_quiet >= 99) nm = 1;
            end
            m_mode = nm; m_left = nl;
            if (surge_in) m_quiet = 0;
            else if (m_quiet < 1000) m_quiet++;
            if (m_cnt == 99) begin
                m_duty = (duty_cmd > 100) ? 100 : int'(duty_cmd);
                m_dt   = (dt_cfg == 0) ? 1 : int'(dt_cfg);
            end
            m_cnt = (m_cnt + 1) % 100;
        end
    end

    function automatic bit e_side(int i, bit high);
        bit on;
        on = (m_mode != 0) && (m_age[i] >= m_gap[i]);
        return high ? (on && m_prev[i] == 1) : (on && m_prev[i] == 0);
    endfunction

    task automatic chk(input bit act, input bit exp, input string grp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s]: actual %0b expected %0b at %0t", grp, scen, act, exp, $time);
        end
    endtask

    // Compare every gate on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(g_chg_hi, (m_mode == 2) && e_side(0, 1'b0), "R7 charge hi");
            chk(g_chg_lo, (m_mode == 2) && e_side(0, 1'b0), "R7 charge lo");
            chk(g_tap_up, m_mode == 1, "R6 tap up");
            chk(g_tap_lo, m_mode == 1, "R6 tap lo");
            chk(g_link,   m_mode == 3, "R9 link");
            chk(g_up_hs,  e_side(0, 1'b1), "R2 up hs");
            chk(g_up_ls,  e_side(0, 1'b0), "R2 up ls");
            chk(g_lo_hs,  e_side(1, 1'b1), "R3 lo hs");
            chk(g_lo_ls,  e_side(1, 1'b0), "R3 lo ls");
            chk((g_up_hs && g_up_ls) || (g_lo_hs && g_lo_ls), 1'b0, "R4 pair overlap");
            chk(g_link && (g_tap_up || g_tap_lo || g_chg_hi), 1'b0, "R11 link exclusive");
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R8: charge-on clocks over one whole period
    task automatic count_chg(input int exp);
        int n;
        n = 0;
        repeat (100) begin
            @(negedge clk);
            if (g_chg_hi) n++;
        end
        checks++;
        if (n != exp) begin
            errors++;
            $display("FAIL R8 window length [%s]: actual %0d expected %0d", scen, n, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: all gates low in reset
        repeat (4) begin
            @(negedge clk);
            chk(g_chg_hi | g_chg_lo | g_tap_up | g_tap_lo | g_link, 1'b0, "R1 divider gates");
            chk(g_up_hs | g_up_ls | g_lo_hs | g_lo_ls, 1'b0, "R1 phase gates");
        end
        rst_n = 1'b1;
        // R1: first clock after reset checked by the reference (idle)
        scen = "R5 duty 30 dt 2"; duty_cmd = 7'd30; dt_cfg = 2'd2; chg_len = 6'd10;
        run(250);
        count_chg(10);
        // R5: duty changed mid-period, applies only at the boundary
        run(37);
        scen = "R8 window cut"; duty_cmd = 7'd70; chg_len = 6'd40;
        run(250);
        count_chg(27);
        scen = "R5 duty 0 dt 3"; duty_cmd = 7'd0; dt_cfg = 2'd3; chg_len = 6'd20;
        run(250);
        count_chg(20);
        scen = "R5 clamp and dt 0"; duty_cmd = 7'd120; dt_cfg = 2'd0;
        run(250);
        count_chg(0);
        scen = "R8 zero length"; duty_cmd = 7'd45; dt_cfg = 2'd1; chg_len = 6'd0;
        run(250);
        count_chg(0);
        scen = "R9 surge"; chg_len = 6'd15; duty_cmd = 7'd40;
        run(223);
        surge_in = 1'b1; run(5); surge_in = 1'b0;
        scen = "R10 quiet exit";
        run(260);
        surge_in = 1'b1; run(1); surge_in = 1'b0;
        run(60);
        surge_in = 1'b1; run(1); surge_in = 1'b0;
        run(300);
        count_chg(15);
        finish_run();
    end
endmodule